// File: doc/BRIEF.md
# Ramp-Compare Hit Time Digitizer

This block turns an analog level into a number by measuring time alone. It drives a square wave, taken from the system clock, out to an external RC network that shapes it into a rising and falling reference ramp. An external comparator sees the ramp against the analog input. Its output, together with a fine interpolation code from an external delay-chain stage, comes back into the block. In every ramp half the block records the first comparator change. The record holds the clock count since the start of that half, the fine code, and a bit that gives the ramp direction. A half in which the comparator never moves produces a record marked as having no hit.

A table, one curve for each ramp direction, turns each hit time into an amplitude. The record and its amplitude go into a buffer. A four-wire serial port starts and stops sampling, loads the table, and pops records one at a time. With a 100 MHz clock and the default half length of 50 cycles, the ramp repeats at 1 MHz.

Top module: `ramp_hit_digitizer`

## Requirements
- R1: While stopped, `ramp_out` is low. After sampling starts, `ramp_out` is high for HALF_CYCLES clocks, then low for HALF_CYCLES clocks, and repeats. The first half after a start is a high (rising) half.
- R2: A hit record holds the count of clocks from the `ramp_out` change that opened the half to the clock in which `cmp_in` differs from its previous value. It also holds the `fine_in` value from that clock, and a direction bit that is 1 for a high half and 0 for a low half.
- R3: Only the first comparator change in a ramp half is recorded. Further changes in the same half produce no record.
- R4: A half with no comparator change produces one record with the no-hit bit set and zero count, fine code and amplitude.
- R5: Each completed ramp half yields exactly one record. No records are made while stopped.
- R6: The amplitude of a hit equals the table entry at index {direction, count[9:5]}, which is the direction times 32 plus the count divided by 32. Table entries are written by command 01, with the index in bits [29:24] and the value in bits [11:0].
- R7: Records are read in arrival order. A read frame (command 10) returns the oldest record and removes it. The returned word is {empty[31], overflow[30], direction[29], no-hit[28], count[27:18], fine[17:12], amplitude[11:0]}. When the buffer is empty, bit 31 is 1 and nothing is removed.
- R8: When 64 records are held, new records are dropped and the overflow bit (bit 30 of every returned word) is set. It stays set until a control command (00) with bit 1 set clears it.
- R9: A frame is 32 bits. `mosi` is taken MSB first on `sclk` rising edges and `miso` presents the returned word MSB first. The command in bits [31:30] is acted on when `cs_n` rises. Command 00 sets run from bit 0. Command 11 changes nothing, and in particular removes no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmp_in | input | 1 | Comparator output, ramp against analog input |
| fine_in | input | 6 | Fine interpolation code valid with a comparator change |
| ramp_out | output | 1 | Square wave to the external RC ramp network |
| sclk | input | 1 | Serial port clock |
| cs_n | input | 1 | Serial port frame select, active low |
| mosi | input | 1 | Serial command data in |
| miso | output | 1 | Serial response data out |

## Verification
The count in a record is due in the clock where the bench changes `cmp_in`. The bench observes each `ramp_out` change at a falling clock edge, counts whole clocks from there, and changes the comparator at a falling edge. The expected count is therefore the number of clocks it waited. A record reaches the buffer two clocks after its capture clock, because table conversion and the buffer write each add one register. Commands take effect about three clocks after `cs_n` rises, because of the two-stage synchronizers. The bench therefore reads the buffer only after a stop frame has finished, and waits eight clocks after each frame, so no check depends on when a record lands relative to a read.

// File: rtl/rhd_pkg.sv
package rhd_pkg;
  localparam int COARSE_W  = 10;
  localparam int FINE_W    = 6;
  localparam int AMP_W     = 12;
  localparam int LUT_IDX_W = 6;
  localparam int FRAME_W   = 32;

  typedef struct packed {
    logic                dir;
    logic                nohit;
    logic [COARSE_W-1:0] coarse;
    logic [FINE_W-1:0]   fine;
  } hit_rec_t;

  typedef struct packed {
    hit_rec_t         rec;
    logic [AMP_W-1:0] amp;
  } buf_word_t;

  typedef enum logic [1:0] {
    CMD_CTRL = 2'b00,
    CMD_LUT  = 2'b01,
    CMD_READ = 2'b10,
    CMD_NOP  = 2'b11
  } cmd_t;

  // table index: direction on top, upper count bits below
  function automatic logic [LUT_IDX_W-1:0] lut_index(hit_rec_t r);
    return {r.dir, r.coarse[COARSE_W-1 -: LUT_IDX_W-1]};
  endfunction

  function automatic hit_rec_t make_hit(logic dir, logic [COARSE_W-1:0] cnt,
                                        logic [FINE_W-1:0] fine);
    return '{dir: dir, nohit: 1'b0, coarse: cnt, fine: fine};
  endfunction

  function automatic hit_rec_t make_miss(logic dir);
    return '{dir: dir, nohit: 1'b1, coarse: '0, fine: '0};
  endfunction

  function automatic logic [FRAME_W-1:0] read_word(logic empty, logic ovf, buf_word_t w);
    return {empty, ovf, (empty ? '0 : w)};
  endfunction
endpackage

// File: rtl/rhd_ramp_gen.sv
module rhd_ramp_gen
  import rhd_pkg::*;
#(
  parameter int HALF_CYCLES = 50
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                running,
  output logic [COARSE_W-1:0] cnt,
  output logic                half_end,
  output logic                dir,
  output logic                ramp_out
);
  localparam logic [COARSE_W-1:0] LAST = COARSE_W'(HALF_CYCLES - 1);

  assign half_end = running && (cnt == LAST);
  assign ramp_out = running & dir;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      dir <= 1'b1;
    end else if (!running) begin
      cnt <= '0;
      dir <= 1'b1;
    end else if (half_end) begin
      cnt <= '0;
      dir <= ~dir;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rhd_hit_capture.sv
module rhd_hit_capture
  import rhd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                running,
  input  logic                half_end,
  input  logic                dir,
  input  logic [COARSE_W-1:0] cnt,
  input  logic                cmp_in,
  input  logic [FINE_W-1:0]   fine_in,
  output logic                toggle,
  output logic                armed,
  output logic                rec_valid,
  output hit_rec_t            rec
);
  logic cmp_prev;

  assign toggle    = cmp_in ^ cmp_prev;
  assign rec_valid = running && armed && (toggle || half_end);
  assign rec       = toggle ? make_hit(dir, cnt, fine_in) : make_miss(dir);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_prev <= 1'b0;
      armed    <= 1'b1;
    end else begin
      cmp_prev <= cmp_in;
      if (!running || half_end) armed <= 1'b1;
      else if (toggle)          armed <= 1'b0;
    end
  end
endmodule

// File: rtl/rhd_lut_conv.sv
module rhd_lut_conv
  import rhd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  hit_rec_t             in_rec,
  input  logic                 lut_we,
  input  logic [LUT_IDX_W-1:0] lut_addr,
  input  logic [AMP_W-1:0]     lut_data,
  output logic                 out_valid,
  output buf_word_t            out_word
);
  localparam int ENTRIES = 1 << LUT_IDX_W;
  logic [AMP_W-1:0] table_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (lut_we) table_q[lut_addr] <= lut_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid    <= in_valid;
      out_word.rec <= in_rec;
      out_word.amp <= in_rec.nohit ? '0 : table_q[lut_index(in_rec)];
    end
  end
endmodule

// File: rtl/rhd_fifo.sv
module rhd_fifo
  import rhd_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_req,
  input  buf_word_t          wr_word,
  input  logic               rd_req,
  input  logic               clr_ovf,
  output buf_word_t          head,
  output logic               empty,
  output logic               full,
  output logic               ovf,
  output logic [$clog2(DEPTH):0] count
);
  localparam int AW = $clog2(DEPTH);
  buf_word_t mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic push, pop, drop;

  assign empty = (count == 0);
  assign full  = (count == (AW+1)'(DEPTH));
  assign push  = wr_req && !full;
  assign drop  = wr_req && full;
  assign pop   = rd_req && !empty;
  assign head  = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
      if (drop)         ovf <= 1'b1;
      else if (clr_ovf) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/rhd_serial_port.sv
module rhd_serial_port
  import rhd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 mosi,
  output logic                 miso,
  input  buf_word_t            head,
  input  logic                 empty,
  input  logic                 ovf,
  output logic                 running,
  output logic                 clr_ovf,
  output logic                 lut_we,
  output logic [LUT_IDX_W-1:0] lut_addr,
  output logic [AMP_W-1:0]     lut_data,
  output logic                 pop
);
  logic [2:0] sclk_sy, cs_sy;
  logic [1:0] mosi_sy;
  logic [FRAME_W-1:0] rx, tx;
  logic tx_empty;
  logic sclk_rise, cs_fall, cs_rise, cs_act;

  assign sclk_rise = sclk_sy[1] & ~sclk_sy[2];
  assign cs_fall   = ~cs_sy[1] & cs_sy[2];
  assign cs_rise   = cs_sy[1] & ~cs_sy[2];
  assign cs_act    = ~cs_sy[1];
  assign miso      = tx[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_sy  <= '0;
      cs_sy    <= '1;
      mosi_sy  <= '0;
      rx       <= '0;
      tx       <= '0;
      tx_empty <= 1'b1;
      running  <= 1'b0;
      clr_ovf  <= 1'b0;
      lut_we   <= 1'b0;
      lut_addr <= '0;
      lut_data <= '0;
      pop      <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[1:0], sclk};
      cs_sy   <= {cs_sy[1:0], cs_n};
      mosi_sy <= {mosi_sy[0], mosi};
      clr_ovf <= 1'b0;
      lut_we  <= 1'b0;
      pop     <= 1'b0;
      if (cs_fall) begin
        tx       <= read_word(empty, ovf, head);
        tx_empty <= empty;
      end else if (sclk_rise && cs_act) begin
        rx <= {rx[FRAME_W-2:0], mosi_sy[1]};
        tx <= {tx[FRAME_W-2:0], 1'b0};
      end
      if (cs_rise) begin
        unique case (cmd_t'(rx[FRAME_W-1 -: 2]))
          CMD_CTRL: begin
            running <= rx[0];
            clr_ovf <= rx[1];
          end
          CMD_LUT: begin
            lut_we   <= 1'b1;
            lut_addr <= rx[FRAME_W-3 -: LUT_IDX_W];
            lut_data <= rx[AMP_W-1:0];
          end
          CMD_READ: pop <= ~tx_empty;
          CMD_NOP:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ramp_hit_digitizer.sv
module ramp_hit_digitizer
  import rhd_pkg::*;
#(
  parameter int HALF_CYCLES = 50,
  parameter int FIFO_DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_in,
  input  logic [FINE_W-1:0] fine_in,
  output logic              ramp_out,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  // named internal events, visible to the bound checker
  logic                 running, half_end, ramp_dir, toggle, armed;
  logic [COARSE_W-1:0]  half_cnt;
  logic                 rec_valid, conv_valid;
  hit_rec_t             rec;
  buf_word_t            conv_word, head;
  logic                 lut_we, pop, clr_ovf, buf_empty, buf_full, buf_ovf;
  logic [LUT_IDX_W-1:0] lut_addr;
  logic [AMP_W-1:0]     lut_data;
  logic [CW-1:0]        buf_count;

  rhd_ramp_gen #(.HALF_CYCLES(HALF_CYCLES)) u_ramp (
    .clk(clk), .rst_n(rst_n), .running(running), .cnt(half_cnt),
    .half_end(half_end), .dir(ramp_dir), .ramp_out(ramp_out));

  rhd_hit_capture u_cap (
    .clk(clk), .rst_n(rst_n), .running(running), .half_end(half_end),
    .dir(ramp_dir), .cnt(half_cnt), .cmp_in(cmp_in), .fine_in(fine_in),
    .toggle(toggle), .armed(armed), .rec_valid(rec_valid), .rec(rec));

  rhd_lut_conv u_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(rec_valid), .in_rec(rec),
    .lut_we(lut_we), .lut_addr(lut_addr), .lut_data(lut_data),
    .out_valid(conv_valid), .out_word(conv_word));

  rhd_fifo #(.DEPTH(FIFO_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_req(conv_valid), .wr_word(conv_word),
    .rd_req(pop), .clr_ovf(clr_ovf), .head(head), .empty(buf_empty),
    .full(buf_full), .ovf(buf_ovf), .count(buf_count));

  rhd_serial_port u_port (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .head(head), .empty(buf_empty), .ovf(buf_ovf),
    .running(running), .clr_ovf(clr_ovf), .lut_we(lut_we),
    .lut_addr(lut_addr), .lut_data(lut_data), .pop(pop));
endmodule

// File: rtl/rhd_checker.sv
module rhd_checker
  import rhd_pkg::*;
#(
  parameter int HALF_CYCLES = 50,
  parameter int FIFO_DEPTH  = 64
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        running,
  input logic                        half_end,
  input logic                        ramp_dir,
  input logic                        ramp_out,
  input logic                        rec_valid,
  input hit_rec_t                    rec,
  input logic                        conv_valid,
  input logic                        buf_full,
  input logic                        buf_ovf,
  input logic                        clr_ovf,
  input logic [$clog2(FIFO_DEPTH):0] buf_count
);
  logic [1:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n)                     seen <= '0;
    else if (!running || half_end)  seen <= '0;
    else if (rec_valid && seen != 2'd3) seen <= seen + 1'b1;
  end

  p_low_when_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !ramp_out);
  p_dir_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !half_end) |=> ($stable(ramp_dir) || !running));
  p_dir_flips_r1: assert property (@(posedge clk) disable iff (!rst_n)
    half_end |=> (ramp_dir != $past(ramp_dir)) || !running);
  p_count_in_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec.nohit) |-> (rec.coarse < COARSE_W'(HALF_CYCLES)));
  p_first_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (seen == 2'd0));
  p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec.nohit) |-> (rec.coarse == '0 && rec.fine == '0));
  p_one_per_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    half_end |-> ((seen == 2'd0 && rec_valid) || (seen == 2'd1 && !rec_valid)));
  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_count <= ($clog2(FIFO_DEPTH)+1)'(FIFO_DEPTH));
  p_drop_sets_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && buf_full) |=> buf_ovf);
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_ovf && !clr_ovf) |=> buf_ovf);
endmodule

bind ramp_hit_digitizer rhd_checker #(.HALF_CYCLES(HALF_CYCLES), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .half_end(half_end),
  .ramp_dir(ramp_dir), .ramp_out(ramp_out), .rec_valid(rec_valid), .rec(rec),
  .conv_valid(conv_valid), .buf_full(buf_full), .buf_ovf(buf_ovf),
  .clr_ovf(clr_ovf), .buf_count(buf_count));

// File: tb/ramp_hit_digitizer_tb.sv
module ramp_hit_digitizer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 50;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0, cmp_in = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [5:0] fine_in = '0;
  logic ramp_out, miso;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ramp_hit_digitizer #(.HALF_CYCLES(HALF), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .fine_in(fine_in),
    .ramp_out(ramp_out), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] lutv(input int a);
    return 12'(a * 37 + 291);
  endfunction

  task automatic xfer(input logic [31:0] cmd, output logic [31:0] resp);
    @(negedge clk) cs_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 31; i >= 0; i--) begin
      mosi = cmd[i];
      repeat (4) @(negedge clk);
      resp[i] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic ctrl(input logic run, input logic clr);
    logic [31:0] r;
    xfer({2'b00, 28'd0, clr, run}, r);
  endtask

  task automatic rd(output logic [31:0] w);
    xfer({2'b10, 30'd0}, w);
  endtask

  task automatic wait_edge();
    logic l;
    l = ramp_out;
    do @(negedge clk); while (ramp_out == l);
  endtask

  task automatic t_reset();
    logic [31:0] w;
    chk("R1 ramp low after reset", 32'(ramp_out), 32'd0);
    rd(w);
    chk("R7 empty after reset", 32'(w[31:30]), 32'b10);
  endtask

  task automatic t_lut_load();
    logic [31:0] r;
    int a [4] = '{0, 1, 32, 33};
    foreach (a[i]) xfer({2'b01, 6'(a[i]), 12'd0, lutv(a[i])}, r);
  endtask

  task automatic t_ramp();
    logic [31:0] w;
    int n;
    ctrl(1'b1, 1'b0);
    if (ramp_out) wait_edge();
    wait_edge();
    n = 0;
    do begin @(negedge clk); n++; end while (ramp_out == 1'b1);
    chk("R1 high half length", 32'(n), 32'(HALF));
    n = 0;
    do begin @(negedge clk); n++; end while (ramp_out == 1'b0);
    chk("R1 low half length", 32'(n), 32'(HALF));
    ctrl(1'b0, 1'b0);
    chk("R1 ramp low when stopped", 32'(ramp_out), 32'd0);
    for (int g = 0; g < 40; g++) begin
      rd(w);
      if (w[31]) break;
      chk("R4 no-hit record fields", {3'b0, w[28:0]}, {3'b0, 1'b1, 28'd0});
    end
  endtask

  task automatic t_hits();
    int k1 [6] = '{7, 40, 0, 49, -1, 10};
    int k2 [6] = '{-1, -1, -1, -1, -1, 20};
    logic [5:0] fv [6] = '{6'd13, 6'd5, 6'd63, 6'd1, 6'd0, 6'd22};
    logic [31:0] exp [6];
    logic [31:0] w, wn;
    logic d;
    int idx;
    ctrl(1'b1, 1'b0);
    for (int h = 0; h < 6; h++) begin
      wait_edge();
      d = ramp_out;
      if (k1[h] < 0) exp[h] = {2'b00, d, 1'b1, 28'd0};
      else exp[h] = {2'b00, d, 1'b0, 10'(k1[h]), fv[h],
                     lutv(int'(d) * 32 + k1[h] / 32)};
      if (k1[h] >= 0) begin
        repeat (k1[h]) @(negedge clk);
        cmp_in = ~cmp_in;
        fine_in = fv[h];
      end
      if (k2[h] >= 0) begin
        repeat (k2[h] - k1[h]) @(negedge clk);
        cmp_in = ~cmp_in;
        fine_in = 6'd9;
      end
    end
    ctrl(1'b0, 1'b0);
    xfer({2'b11, 30'd0}, wn);
    rd(w);
    chk("R9 command 11 removes nothing", w, wn);
    for (int g = 0; g < 20 && w[28] && !w[31]; g++) rd(w);
    idx = 0;
    for (int g = 0; g < 40 && !w[31]; g++) begin
      if (idx < 6) begin
        chk($sformatf("R2 R3 R6 R7 record %0d", idx), w, exp[idx]);
        idx++;
      end else begin
        chk("R5 trailing half is one no-hit record", {3'b0, w[28:0]}, {3'b0, 1'b1, 28'd0});
      end
      rd(w);
    end
    chk("R7 all scenario records read", 32'(idx), 32'd6);
  endtask

  task automatic t_stopped();
    logic [31:0] w;
    for (int i = 0; i < 6; i++) begin
      repeat (30) @(negedge clk);
      cmp_in = ~cmp_in;
    end
    rd(w);
    chk("R5 no records while stopped", 32'(w[31]), 32'd1);
    chk("R1 ramp still low while stopped", 32'(ramp_out), 32'd0);
  endtask

  task automatic t_overflow();
    logic [31:0] w;
    int n;
    ctrl(1'b1, 1'b0);
    repeat (75 * HALF) @(negedge clk);
    ctrl(1'b0, 1'b0);
    n = 0;
    rd(w);
    chk("R8 overflow flagged on first read", 32'(w[30]), 32'd1);
    while (!w[31] && n < 80) begin
      n++;
      rd(w);
    end
    chk("R8 buffer held exactly 64", 32'(n), 32'(DEPTH));
    chk("R8 overflow still set when drained", 32'(w[31:30]), 32'b11);
    ctrl(1'b0, 1'b1);
    rd(w);
    chk("R8 overflow cleared by command", 32'(w[31:30]), 32'b10);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_lut_load();
    t_ramp();
    t_hits();
    t_stopped();
    t_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule